// File: doc/BRIEF.md
# Clock Source Select and Divider Tree

This block produces every timing strobe that a small microcontroller core and its peripherals need. All of it runs in one fast base clock domain and uses one-cycle enable pulses in place of derived clocks. Two oscillator strobes enter the block: one from the external crystal path and one from the internal on-chip oscillator. A select pin chooses between them. The block samples that pin while a reset is active, except when the reset comes from the watchdog. In that case the earlier choice stays in force.

The chosen oscillator strobe goes through a programmable divider to form the system clock enable. A separate watch clock strobe goes through a second programmable divider to form the subclock enable. Two free-running prescalers produce binary-weighted tick enables for the peripherals. One advances on the system clock enable. The other advances on the watch clock taken at a quarter of its rate. A rate change on either divider waits for the current period to finish and then starts a full new period, so no shortened period appears.

Top module: `clkgen_top`

## Requirements
- R1: During a reset with `rst_is_wdt`=0, the block latches `src_pin`. A latched 1 makes `osc_ext_en` the divider input. A latched 0 makes `osc_int_en` the divider input.
- R2: A reset with `rst_is_wdt`=1 ignores `src_pin` and keeps the source that was selected before that reset.
- R3: `sys_div_sel` codes 0, 1, 2, 3 and 4 divide the selected oscillator strobe by 1, 8, 16, 32 and 64. Codes 5, 6 and 7 divide by 64. `sys_en` pulses in the cycle after each selected strobe whose count since reset (or since the last rate switch) is a multiple of the divisor.
- R4: `sub_div_sel` codes 0, 1 and 2 divide `watch_en` by 2, 4 and 8. Code 3 divides by 8. `sub_en` pulses in the cycle after the completing watch strobe.
- R5: `pre_s_tap[i]` pulses in the cycle after the `sys_en` pulse whose count since reset is a multiple of 2^(i+1). Bit 0 therefore runs at half the system rate and bit 16 at 1/131072 of it.
- R6: `pre_w_tap[j]` pulses in the cycle after the `watch_en` strobe whose count since reset is a multiple of 2^(j+3). Bit 0 therefore runs at 1/8 of the watch rate and bit 7 at 1/1024 of it.
- R7: A new divider select takes effect only when a pulse completes at the current rate. At that moment the count restarts, and the first pulse at the new rate comes a full new period later.
- R8: Every reset, including a watchdog reset, clears the divider and prescaler counts. All outputs are low in the cycle after a reset edge, and counting starts again from zero.
- R9: Strobes from the oscillator that is not selected have no effect on `sys_en` or on `pre_s_tap`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock for all logic |
| rst | input | 1 | Synchronous active-high reset |
| rst_is_wdt | input | 1 | Marks the current reset as a watchdog reset |
| src_pin | input | 1 | Source select level: 1 external, 0 internal |
| osc_ext_en | input | 1 | External oscillator strobe |
| osc_int_en | input | 1 | Internal oscillator strobe |
| watch_en | input | 1 | Watch clock strobe |
| sys_div_sel | input | 3 | System divider select code |
| sub_div_sel | input | 2 | Subclock divider select code |
| sys_en | output | 1 | System clock enable pulse |
| sub_en | output | 1 | Subclock enable pulse |
| pre_s_tap | output | 17 | System prescaler tick enables |
| pre_w_tap | output | 8 | Watch prescaler tick enables |

## Verification
Two functions can fall in the same cycle. The first is a divider select change. The second is the terminal count that completes a period at the old rate, which is exactly the cycle where the switch is allowed to happen. The bench changes both selects halfway through every sweep run, while the strobe patterns are pseudo-random. As a result, some changes arrive on the completing strobe and others arrive in the middle of a period. The bench judges each case against an arithmetic count model: the pulse at the old rate must still appear, and the new period must be counted in full from zero. The same runs also drive watchdog resets into periods that are partly counted. This confirms that the counts clear while the latched source survives.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;
  localparam int SYS_CW    = 6;   // counts up to divide-by-64
  localparam int SUB_CW    = 3;   // counts up to divide-by-8
  localparam int PRE_S_W   = 17;  // system prescaler width
  localparam int PRE_W_W   = 10;  // watch prescaler width including /4 stage
  localparam int PRE_W_SKP = 2;   // low stages that form the /4 pre-divide

  // system select code -> log2 of divisor
  function automatic logic [2:0] sys_shift(input logic [2:0] code);
    case (code)
      3'd0:    sys_shift = 3'd0;
      3'd1:    sys_shift = 3'd3;
      3'd2:    sys_shift = 3'd4;
      3'd3:    sys_shift = 3'd5;
      default: sys_shift = 3'd6;
    endcase
  endfunction

  // subclock select code -> log2 of divisor
  function automatic logic [1:0] sub_shift(input logic [1:0] code);
    case (code)
      2'd0:    sub_shift = 2'd1;
      2'd1:    sub_shift = 2'd2;
      default: sub_shift = 2'd3;
    endcase
  endfunction
endpackage

// File: rtl/rate_divider.sv
module rate_divider #(
  parameter int CW  = 6,
  parameter int SHW = $clog2(CW + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_en,
  input  logic [SHW-1:0] req_shift,
  output logic           out_en
);
  logic [CW-1:0]  cnt;
  logic [SHW-1:0] act_shift;
  logic [CW-1:0]  mask;
  logic           term;

  always_comb begin
    mask = ~({CW{1'b1}} << act_shift);
    term = ((cnt & mask) == mask);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      act_shift <= req_shift;
      out_en    <= 1'b0;
    end else begin
      out_en <= in_en & term;
      if (in_en) begin
        if (term && (req_shift != act_shift)) begin
          act_shift <= req_shift;
          cnt       <= '0;
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int W   = 17,
  parameter int SKP = 0,
  localparam int TW = W - SKP
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  output logic [TW-1:0] taps
);
  logic [W-1:0]  cnt;
  logic [TW-1:0] roll;

  for (genvar i = SKP; i < W; i++) begin : g_roll
    assign roll[i-SKP] = &cnt[i:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      taps <= '0;
    end else begin
      taps <= adv ? roll : '0;
      if (adv) cnt <= cnt + W'(1);
    end
  end
endmodule

// File: rtl/src_latch.sv
module src_latch (
  input  logic clk,
  input  logic rst,
  input  logic rst_wdt,
  input  logic pin,
  output logic sel_ext
);
  always_ff @(posedge clk) begin
    if (rst && !rst_wdt) sel_ext <= pin;
  end
endmodule

// File: rtl/clkgen_top.sv
module clkgen_top
  import clkgen_pkg::*;
#(
  parameter int SYS_W  = SYS_CW,
  parameter int SUB_W  = SUB_CW,
  parameter int PS_W   = PRE_S_W,
  parameter int PW_W   = PRE_W_W,
  parameter int PW_SKP = PRE_W_SKP,
  localparam int SYS_SHW = $clog2(SYS_W + 1),
  localparam int SUB_SHW = $clog2(SUB_W + 1),
  localparam int PW_TW   = PW_W - PW_SKP
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rst_is_wdt,
  input  logic             src_pin,
  input  logic             osc_ext_en,
  input  logic             osc_int_en,
  input  logic             watch_en,
  input  logic [2:0]       sys_div_sel,
  input  logic [1:0]       sub_div_sel,
  output logic             sys_en,
  output logic             sub_en,
  output logic [PS_W-1:0]  pre_s_tap,
  output logic [PW_TW-1:0] pre_w_tap
);
  logic               src_ext;
  logic               osc_pick;
  logic [SYS_SHW-1:0] sys_req;
  logic [SUB_SHW-1:0] sub_req;

  src_latch u_src (
    .clk     (clk),
    .rst     (rst),
    .rst_wdt (rst_is_wdt),
    .pin     (src_pin),
    .sel_ext (src_ext)
  );

  always_comb begin
    osc_pick = src_ext ? osc_ext_en : osc_int_en;
    sys_req  = SYS_SHW'(sys_shift(sys_div_sel));
    sub_req  = SUB_SHW'(sub_shift(sub_div_sel));
  end

  rate_divider #(.CW(SYS_W)) u_sys_div (
    .clk       (clk),
    .rst       (rst),
    .in_en     (osc_pick),
    .req_shift (sys_req),
    .out_en    (sys_en)
  );

  rate_divider #(.CW(SUB_W)) u_sub_div (
    .clk       (clk),
    .rst       (rst),
    .in_en     (watch_en),
    .req_shift (sub_req),
    .out_en    (sub_en)
  );

  tick_prescaler #(.W(PS_W), .SKP(0)) u_pre_s (
    .clk  (clk),
    .rst  (rst),
    .adv  (sys_en),
    .taps (pre_s_tap)
  );

  tick_prescaler #(.W(PW_W), .SKP(PW_SKP)) u_pre_w (
    .clk  (clk),
    .rst  (rst),
    .adv  (watch_en),
    .taps (pre_w_tap)
  );
endmodule

// File: rtl/clkgen_chk.sv
module clkgen_chk #(
  parameter int PS = 17,
  parameter int PW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          rst_is_wdt,
  input logic          src_pin,
  input logic          osc_ext_en,
  input logic          osc_int_en,
  input logic          watch_en,
  input logic          sys_en,
  input logic          sub_en,
  input logic [PS-1:0] pre_s_tap,
  input logic [PW-1:0] pre_w_tap,
  input logic          src_ext
);
  logic por_seen = 1'b0;

  always_ff @(posedge clk) begin
    if (rst && !rst_is_wdt) por_seen <= 1'b1;
  end

  assert_pin_latched_R1: assert property (@(posedge clk) disable iff (rst)
    ($fell(rst) && !$past(rst_is_wdt)) |-> (src_ext == $past(src_pin)));

  assert_wdt_keeps_src_R2: assert property (@(posedge clk) disable iff (rst)
    ($fell(rst) && $past(rst_is_wdt) && por_seen) |-> (src_ext == $past(src_ext)));

  assert_sys_needs_strobe_R3: assert property (@(posedge clk) disable iff (rst)
    sys_en |-> $past(osc_ext_en || osc_int_en));

  assert_sub_needs_watch_R4: assert property (@(posedge clk) disable iff (rst)
    sub_en |-> $past(watch_en));

  assert_stap_follows_sys_R5: assert property (@(posedge clk) disable iff (rst)
    (pre_s_tap != '0) |-> $past(sys_en));

  assert_stap_nested_R5: assert property (@(posedge clk) disable iff (rst)
    (((pre_s_tap >> 1) & ~pre_s_tap) == '0));

  assert_wtap_follows_watch_R6: assert property (@(posedge clk) disable iff (rst)
    (pre_w_tap != '0) |-> $past(watch_en));

  assert_cleared_after_reset_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!sys_en && !sub_en && pre_s_tap == '0 && pre_w_tap == '0));
endmodule

bind clkgen_top clkgen_chk #(.PS(PS_W), .PW(PW_TW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .rst_is_wdt (rst_is_wdt),
  .src_pin    (src_pin),
  .osc_ext_en (osc_ext_en),
  .osc_int_en (osc_int_en),
  .watch_en   (watch_en),
  .sys_en     (sys_en),
  .sub_en     (sub_en),
  .pre_s_tap  (pre_s_tap),
  .pre_w_tap  (pre_w_tap),
  .src_ext    (src_ext)
);

// File: tb/clkgen_top_tb.sv
module clkgen_top_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1, rst_is_wdt = 1'b0, src_pin = 1'b0;
  logic        osc_ext_en = 1'b0, osc_int_en = 1'b0, watch_en = 1'b0;
  logic [2:0]  sys_div_sel = 3'd0;
  logic [1:0]  sub_div_sel = 2'd0;
  logic        sys_en, sub_en;
  logic [16:0] pre_s_tap;
  logic [7:0]  pre_w_tap;

  int total = 0, bad = 0;
  string cur_tag = "R3";
  string sub_tag = "R4";

  // arithmetic reference state
  int m_src = 0, m_k = 0, m_d = 1, m_ws = 0, m_ds = 2, m_wp = 0, m_sc = 0;
  bit m_prev = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;

  clkgen_top u_dut (
    .clk(clk), .rst(rst), .rst_is_wdt(rst_is_wdt), .src_pin(src_pin),
    .osc_ext_en(osc_ext_en), .osc_int_en(osc_int_en), .watch_en(watch_en),
    .sys_div_sel(sys_div_sel), .sub_div_sel(sub_div_sel),
    .sys_en(sys_en), .sub_en(sub_en), .pre_s_tap(pre_s_tap), .pre_w_tap(pre_w_tap)
  );

  function automatic int dsys(input logic [2:0] c);
    if (c == 0) return 1;
    if (c <= 4) return 1 << (c + 2);
    return 64;
  endfunction

  function automatic int dsub(input logic [1:0] c);
    if (c == 0) return 2;
    if (c == 1) return 4;
    return 8;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick(input bit r, input bit wd, input bit pin, input bit e,
                      input bit i, input bit w, input logic [2:0] ss, input logic [1:0] sb);
    bit esys, esub;
    logic [16:0] etap;
    logic [7:0]  ewt;
    rst = r; rst_is_wdt = wd; src_pin = pin;
    osc_ext_en = e; osc_int_en = i; watch_en = w;
    sys_div_sel = ss; sub_div_sel = sb;
    @(posedge clk);
    #1;
    esys = 0; esub = 0; etap = '0; ewt = '0;
    if (r) begin
      if (!wd) m_src = pin;
      m_k = 0; m_sc = 0; m_ws = 0; m_wp = 0; m_prev = 0;
      m_d = dsys(ss); m_ds = dsub(sb);
      // R8: outputs cleared by any reset
      chk("R8 sys", {31'd0, sys_en}, 32'd0);
      chk("R8 taps", {7'd0, pre_s_tap, pre_w_tap}, 32'd0);
    end else begin
      if (m_src ? e : i) begin
        m_k++;
        if (m_k % m_d == 0) begin
          esys = 1;
          if (dsys(ss) != m_d) begin m_d = dsys(ss); m_k = 0; end
        end
      end
      if (m_prev) begin
        m_sc++;
        for (int b = 0; b < 17; b++) if (m_sc % (1 << (b + 1)) == 0) etap[b] = 1'b1;
      end
      m_prev = esys;
      if (w) begin
        m_ws++;
        if (m_ws % m_ds == 0) begin
          esub = 1;
          if (dsub(sb) != m_ds) begin m_ds = dsub(sb); m_ws = 0; end
        end
        m_wp++;
        for (int j = 0; j < 8; j++) if (m_wp % (1 << (j + 3)) == 0) ewt[j] = 1'b1;
      end
      chk({cur_tag, " sys_en"}, {31'd0, sys_en}, {31'd0, esys});
      chk({sub_tag, " sub_en"}, {31'd0, sub_en}, {31'd0, esub});
      chk("R5 pre_s_tap", {15'd0, pre_s_tap}, {15'd0, etap});
      chk("R6 pre_w_tap", {24'd0, pre_w_tap}, {24'd0, ewt});
    end
    @(negedge clk);
  endtask

  function automatic logic [15:0] lfsr_next(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    @(negedge clk);
    // R8 reset state, R1 latch external
    tick(1, 0, 1, 1, 1, 1, 3'd1, 2'd1);
    tick(1, 0, 1, 1, 1, 1, 3'd1, 2'd1);
    cur_tag = "R9";
    for (int n = 0; n < 64; n++) tick(0, 0, 0, 0, 1, 0, 3'd1, 2'd1);
    cur_tag = "R1";
    for (int n = 0; n < 64; n++) tick(0, 0, 0, 1, 0, 1, 3'd1, 2'd1);

    // sweep of source and codes with pseudo-random strobes
    for (int p = 0; p < 2; p++) begin
      for (int c = 0; c < 8; c++) begin
        tick(1, 0, p[0], 0, 0, 0, 3'(c), 2'(c));
        for (int n = 0; n < 250; n++) begin
          lfsr = lfsr_next(lfsr);
          cur_tag = (n < 125) ? "R3" : "R7";
          sub_tag = (n < 125) ? "R4" : "R7";
          tick(0, 0, p[0], lfsr[0] | lfsr[3], lfsr[1] | lfsr[5], lfsr[2],
               (n < 125) ? 3'(c) : 3'((c + 3) % 8),
               (n < 125) ? 2'(c) : 2'((c + 1) % 4));
        end
      end
    end

    // R2: watchdog reset keeps external source despite pin low
    tick(1, 0, 1, 0, 0, 0, 3'd1, 2'd0);
    cur_tag = "R2"; sub_tag = "R4";
    for (int n = 0; n < 21; n++) tick(0, 0, 0, 1, 1, 1, 3'd1, 2'd0);
    tick(1, 1, 0, 1, 1, 1, 3'd1, 2'd0);
    tick(1, 1, 0, 1, 1, 1, 3'd1, 2'd0);
    for (int n = 0; n < 100; n++) tick(0, 0, 0, 1, 0, 0, 3'd1, 2'd0);
    cur_tag = "R9";
    for (int n = 0; n < 100; n++) tick(0, 0, 1, 0, 1, 0, 3'd1, 2'd0);
    // R1: ordinary reset now latches internal source
    tick(1, 0, 0, 0, 0, 0, 3'd1, 2'd0);
    cur_tag = "R1";
    for (int n = 0; n < 100; n++) tick(0, 0, 1, 0, 1, 0, 3'd1, 2'd0);

    // long run reaching the slowest taps (R5, R6)
    tick(1, 0, 1, 0, 0, 0, 3'd0, 2'd0);
    cur_tag = "R5"; sub_tag = "R6";
    for (int n = 0; n < 131080; n++) tick(0, 0, 1, 1, 0, 1, 3'd0, 2'd0);

    finish_run();
  end
endmodule